// File: doc/BRIEF.md
# Dual-Channel Playback Command Controller

This block turns a stream of command bytes from a host port into control for two playback channels. Each command opcode sits in the upper nibble of its first byte. Channel commands carry a two-bit channel mask in bits 1..0, so one command can address either channel or both. Four opcodes take a second byte that holds a phrase number, a silence length or a volume. The controller keeps the state of each channel: idle or playing, whether a next item is queued, and whether repeat mode is on. It emits one-cycle start and stop pulses, the code of the item to play, a silence flag, a volume and a repeat flag for each channel.

An end-of-phrase strobe comes back from the playback engine for each channel. On that strobe the channel repeats its item, moves on to the queued item, or returns to idle. Two active-low status flags per channel show whether the channel is playing (busy) and whether its queue slot is full (not-ready). Every accepted command holds all status flags low for a fixed processing window. The host polls the flags and waits for them to go high before it sends the next command.

Top module: `play_cmd_ctrl`

## Requirements
- R1: While reset is applied and right after it, busyN and ncrN are all ones, pwrOn is 0, and every pulse, code, volume and repeat output is 0.
- R2: The opcode is in byteData[7:4]. PLAY=0x4, FADR=0x6, MUON=0x8 and VOL=0xB use the next accepted byte as their argument. Every other defined opcode is complete in one byte. byteData bit 0 selects channel 1 and bit 1 selects channel 2; bits 3..2 are ignored.
- R3: Once the last byte of a command is accepted, busyN and ncrN are 0 on both channels for exactly PROC_CYCLES (8) clocks. Bytes that arrive during this window are dropped.
- R4: PLAY sent to an idle channel gives a chStart pulse in the cycle after the argument byte. chCode is set to the argument and chSilence to 0, and the channel counts as playing (busyN low) until it returns to idle.
- R5: PLAY, START or MUON sent to a playing channel with an empty queue stores the item and drives that channel's ncrN low. The same commands are dropped when the queue already holds an item.
- R6: An end-of-phrase strobe on a playing channel that is not repeating starts the queued item with a chStart pulse and empties the queue. With no queued item, the channel goes idle and busyN returns high.
- R7: FADR stores a preset phrase for each selected channel. START (0x5) loads that preset on every selected channel in the same cycle.
- R8: MUON loads an item with chSilence=1 and chCode equal to the silence length.
- R9: SLOOP (0x9) sets chLoop only on a channel that is playing. While chLoop is set, an end-of-phrase strobe restarts the current item. CLOOP (0xA) clears chLoop.
- R10: STOP (0x7) pulses chStop on each selected channel, returns that channel to idle, and clears its queue and its repeat mode.
- R11: VOL sets chVol of each selected channel to the argument. No other command changes chVol.
- R12: Opcodes 0x0 and 0x1 set pwrOn. Opcodes 0x2 and 0x3 clear it.
- R13: Opcodes 0xD to 0xF are ignored and open no processing window. Opcode 0xC opens a processing window and has no other effect.
- R14: When a command addresses a channel in the same cycle as that channel's end-of-phrase strobe, the command takes effect and the strobe is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| byteValid | input | 1 | A command byte is present on byteData |
| byteData | input | 8 | Command or argument byte |
| phraseEnd | input | 2 | End-of-item strobe for each channel |
| chStart | output | 2 | One-cycle start pulse for each channel |
| chStop | output | 2 | One-cycle stop pulse for each channel |
| chSilence | output | 2 | The current item is a silence interval |
| chCode | output | 16 | Phrase number or silence length, 8 bits per channel |
| chVol | output | 16 | Volume, 8 bits per channel |
| chLoop | output | 2 | Repeat mode for each channel |
| busyN | output | 2 | Low while processing a command or while the channel plays |
| ncrN | output | 2 | Low while processing a command or while the channel queue is full |
| pwrOn | output | 1 | Power-up state set by the power commands |

## Verification
The assertions rely on byteValid and phraseEnd being clean, synchronous one-cycle strobes, and on reset being held for at least one clock edge before it is released. They place no limit on how bytes are spaced. The stimulus drives every input on the falling edge. It sends random bytes at random points, including points inside the processing window and between the two bytes of a command. It also raises end-of-phrase strobes in the same cycle as commands, so the dropping and priority rules are exercised as well as the plain flows.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  localparam int BYTE_W = 8;
  localparam int CH_NUM = 2;

  typedef enum logic [3:0] {
    OP_PWRUP_FAST = 4'h0,
    OP_PWRUP_SOFT = 4'h1,
    OP_PWRDN_FAST = 4'h2,
    OP_PWRDN_SOFT = 4'h3,
    OP_PLAY       = 4'h4,
    OP_START      = 4'h5,
    OP_PRESET     = 4'h6,
    OP_STOP       = 4'h7,
    OP_SILENCE    = 4'h8,
    OP_LOOP_SET   = 4'h9,
    OP_LOOP_CLR   = 4'hA,
    OP_VOLUME     = 4'hB,
    OP_EXTERNAL   = 4'hC
  } opcode_e;

  typedef struct packed {
    logic              commit;
    logic              play;
    logic              start;
    logic              preset;
    logic              stop;
    logic              silence;
    logic              loopSet;
    logic              loopClr;
    logic              volume;
    logic              pwrUp;
    logic              pwrDn;
    logic [CH_NUM-1:0] mask;
    logic [BYTE_W-1:0] arg;
  } cmd_strobes_t;
endpackage

// File: rtl/pcc_ctrl.sv
module pcc_ctrl
  import pcc_pkg::*;
#(
  parameter int PROC_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] byteData,
  output cmd_strobes_t      stb,
  output logic              procActive
);
  localparam int CNT_W = $clog2(PROC_CYCLES + 1);

  logic              haveFirst;
  logic [3:0]        firstOp;
  logic [CH_NUM-1:0] firstMask;
  logic [CNT_W-1:0]  procCnt;
  logic              accept;
  logic [3:0]        newOp;
  logic [3:0]        curOp;

  function automatic logic isTwoByte(input logic [3:0] op);
    return (op == OP_PLAY) || (op == OP_PRESET) || (op == OP_SILENCE) || (op == OP_VOLUME);
  endfunction

  function automatic logic isKnown(input logic [3:0] op);
    return op <= OP_EXTERNAL;
  endfunction

  assign procActive = (procCnt != '0);
  assign accept     = byteValid && !procActive;
  assign newOp      = byteData[BYTE_W-1 -: 4];

  always_comb begin
    stb   = '0;
    curOp = '0;
    if (accept) begin
      if (haveFirst) begin
        stb.commit = 1'b1;
        curOp      = firstOp;
        stb.mask   = firstMask;
        stb.arg    = byteData;
      end else if (isKnown(newOp) && !isTwoByte(newOp)) begin
        stb.commit = 1'b1;
        curOp      = newOp;
        stb.mask   = byteData[CH_NUM-1:0];
      end
    end
    if (stb.commit) begin
      unique case (curOp)
        OP_PWRUP_FAST, OP_PWRUP_SOFT: stb.pwrUp   = 1'b1;
        OP_PWRDN_FAST, OP_PWRDN_SOFT: stb.pwrDn   = 1'b1;
        OP_PLAY:                      stb.play    = 1'b1;
        OP_START:                     stb.start   = 1'b1;
        OP_PRESET:                    stb.preset  = 1'b1;
        OP_STOP:                      stb.stop    = 1'b1;
        OP_SILENCE:                   stb.silence = 1'b1;
        OP_LOOP_SET:                  stb.loopSet = 1'b1;
        OP_LOOP_CLR:                  stb.loopClr = 1'b1;
        OP_VOLUME:                    stb.volume  = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      haveFirst <= 1'b0;
      firstOp   <= '0;
      firstMask <= '0;
      procCnt   <= '0;
    end else begin
      if (accept) begin
        if (haveFirst) begin
          haveFirst <= 1'b0;
        end else if (isTwoByte(newOp)) begin
          haveFirst <= 1'b1;
          firstOp   <= newOp;
          firstMask <= byteData[CH_NUM-1:0];
        end
      end
      if (stb.commit) begin
        procCnt <= CNT_W'(PROC_CYCLES);
      end else if (procActive) begin
        procCnt <= procCnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/pcc_datapath.sv
module pcc_datapath
  import pcc_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  cmd_strobes_t             stb,
  input  logic                     procActive,
  input  logic [CH_NUM-1:0]        phraseEnd,
  output logic [CH_NUM-1:0]        chStart,
  output logic [CH_NUM-1:0]        chStop,
  output logic [CH_NUM-1:0]        chSilence,
  output logic [CH_NUM*BYTE_W-1:0] chCode,
  output logic [CH_NUM*BYTE_W-1:0] chVol,
  output logic [CH_NUM-1:0]        chLoop,
  output logic [CH_NUM-1:0]        busyN,
  output logic [CH_NUM-1:0]        ncrN,
  output logic                     pwrOn
);
  logic chanOp;
  logic isLoad;

  assign chanOp = stb.play | stb.start | stb.silence | stb.preset | stb.stop |
                  stb.loopSet | stb.loopClr | stb.volume;
  assign isLoad = stb.play | stb.start | stb.silence;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          pwrOn <= 1'b0;
    else if (stb.pwrUp) pwrOn <= 1'b1;
    else if (stb.pwrDn) pwrOn <= 1'b0;
  end

  for (genvar i = 0; i < CH_NUM; i++) begin : g_ch
    logic              playing, queued, loopOn, curSil, qSil, startP, stopP;
    logic [BYTE_W-1:0] curCode, qCode, preset, vol, loadCode;
    logic              addressed;

    assign addressed = stb.commit && stb.mask[i] && chanOp;
    assign loadCode  = stb.start ? preset : stb.arg;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        playing <= 1'b0; queued <= 1'b0; loopOn <= 1'b0;
        curSil  <= 1'b0; qSil   <= 1'b0;
        startP  <= 1'b0; stopP  <= 1'b0;
        curCode <= '0;   qCode  <= '0;
        preset  <= '0;   vol    <= '0;
      end else begin
        startP <= 1'b0;
        stopP  <= 1'b0;
        if (addressed) begin
          if (isLoad) begin
            if (!playing) begin
              playing <= 1'b1;
              curCode <= loadCode;
              curSil  <= stb.silence;
              startP  <= 1'b1;
            end else if (!queued) begin
              queued <= 1'b1;
              qCode  <= loadCode;
              qSil   <= stb.silence;
            end
          end
          if (stb.stop) begin
            playing <= 1'b0;
            queued  <= 1'b0;
            loopOn  <= 1'b0;
            stopP   <= 1'b1;
          end
          if (stb.loopSet && playing) loopOn <= 1'b1;
          if (stb.loopClr)            loopOn <= 1'b0;
          if (stb.volume)             vol    <= stb.arg;
          if (stb.preset)             preset <= stb.arg;
        end else if (phraseEnd[i] && playing) begin
          if (loopOn) begin
            startP <= 1'b1;
          end else if (queued) begin
            curCode <= qCode;
            curSil  <= qSil;
            queued  <= 1'b0;
            startP  <= 1'b1;
          end else begin
            playing <= 1'b0;
          end
        end
      end
    end

    assign chStart[i]                  = startP;
    assign chStop[i]                   = stopP;
    assign chSilence[i]                = curSil;
    assign chCode[i*BYTE_W +: BYTE_W]  = curCode;
    assign chVol[i*BYTE_W +: BYTE_W]   = vol;
    assign chLoop[i]                   = loopOn;
    assign busyN[i]                    = ~(procActive | playing);
    assign ncrN[i]                     = ~(procActive | queued);
  end
endmodule

// File: rtl/play_cmd_ctrl.sv
module play_cmd_ctrl
  import pcc_pkg::*;
#(
  parameter int PROC_CYCLES = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        byteValid,
  input  logic [7:0]  byteData,
  input  logic [1:0]  phraseEnd,
  output logic [1:0]  chStart,
  output logic [1:0]  chStop,
  output logic [1:0]  chSilence,
  output logic [15:0] chCode,
  output logic [15:0] chVol,
  output logic [1:0]  chLoop,
  output logic [1:0]  busyN,
  output logic [1:0]  ncrN,
  output logic        pwrOn
);
  cmd_strobes_t cmdStb;
  logic         procActive;

  pcc_ctrl #(.PROC_CYCLES(PROC_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteData(byteData),
    .stb(cmdStb), .procActive(procActive)
  );

  pcc_datapath u_dp (
    .clk(clk), .rstN(rstN), .stb(cmdStb), .procActive(procActive),
    .phraseEnd(phraseEnd), .chStart(chStart), .chStop(chStop),
    .chSilence(chSilence), .chCode(chCode), .chVol(chVol), .chLoop(chLoop),
    .busyN(busyN), .ncrN(ncrN), .pwrOn(pwrOn)
  );
endmodule

// File: rtl/play_cmd_ctrl_checker.sv
module pcc_checker
  import pcc_pkg::*;
(
  input logic         clk,
  input logic         rstN,
  input cmd_strobes_t stb,
  input logic [1:0]   phraseEnd,
  input logic [1:0]   chStart,
  input logic [1:0]   chStop,
  input logic [15:0]  chVol,
  input logic [1:0]   chLoop,
  input logic [1:0]   busyN,
  input logic [1:0]   ncrN,
  input logic         pwrOn
);
  AST_RESET_STATUS: assert property (@(posedge clk)
    !rstN |=> (busyN == 2'b11 && ncrN == 2'b11 && !pwrOn)); // R1

  AST_WINDOW_LOW: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |=> (busyN == 2'b00 && ncrN == 2'b00)); // R3

  AST_COMMIT_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |=> !stb.commit); // R3

  for (genvar i = 0; i < 2; i++) begin : g_chk
    AST_START_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
      chStart[i] |-> $past((stb.commit && stb.mask[i]) || phraseEnd[i])); // R6

    AST_LOOP_PLAYING: assert property (@(posedge clk) disable iff (!rstN)
      chLoop[i] |-> !busyN[i]); // R9

    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
      chStop[i] |-> (!chLoop[i] && !chStart[i])); // R10

    AST_VOL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      !$past(stb.commit && stb.volume && stb.mask[i]) |-> $stable(chVol[i*8 +: 8])); // R11
  end
endmodule

bind play_cmd_ctrl pcc_checker u_chk (
  .clk(clk), .rstN(rstN), .stb(cmdStb), .phraseEnd(phraseEnd),
  .chStart(chStart), .chStop(chStop), .chVol(chVol), .chLoop(chLoop),
  .busyN(busyN), .ncrN(ncrN), .pwrOn(pwrOn)
);

// File: tb/play_cmd_ctrl_tb.sv
`timescale 1ns/1ps
module play_cmd_ctrl_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteData = '0;
  logic [1:0]  phraseEnd = '0;
  logic [1:0]  chStart, chStop, chSilence, chLoop, busyN, ncrN;
  logic [15:0] chCode, chVol;
  logic        pwrOn;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  play_cmd_ctrl u_dut (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteData(byteData),
    .phraseEnd(phraseEnd), .chStart(chStart), .chStop(chStop),
    .chSilence(chSilence), .chCode(chCode), .chVol(chVol), .chLoop(chLoop),
    .busyN(busyN), .ncrN(ncrN), .pwrOn(pwrOn)
  );

  // Reference state, built from the requirements
  bit       mPlay[2], mQueued[2], mLoop[2], mCurSil[2], mQSil[2], mStart[2], mStop[2];
  bit [7:0] mCur[2], mQ[2], mPre[2], mVol[2];
  bit       mPwr, mHave;
  bit [3:0] mOp;
  bit [1:0] mMask;
  int       mCnt;

  function automatic bit twoByte(input bit [3:0] op);
    return op == 4'h4 || op == 4'h6 || op == 4'h8 || op == 4'hB;
  endfunction

  task automatic modelStep(input bit bv, input bit [7:0] bd, input bit [1:0] pe);
    bit commit = 0;
    bit [3:0] op = 0;
    bit [1:0] mask = 0;
    bit [7:0] arg = 0;
    for (int c = 0; c < 2; c++) begin mStart[c] = 0; mStop[c] = 0; end
    if (bv && mCnt == 0) begin
      if (mHave) begin
        commit = 1; op = mOp; mask = mMask; arg = bd; mHave = 0;
      end else if (bd[7:4] <= 4'hC) begin
        if (twoByte(bd[7:4])) begin mHave = 1; mOp = bd[7:4]; mMask = bd[1:0]; end
        else begin commit = 1; op = bd[7:4]; mask = bd[1:0]; end
      end
    end
    if (commit) mCnt = 8; else if (mCnt > 0) mCnt--;
    if (commit && op <= 4'h1) mPwr = 1;
    if (commit && (op == 4'h2 || op == 4'h3)) mPwr = 0;
    for (int c = 0; c < 2; c++) begin
      if (commit && mask[c] && op >= 4'h4 && op <= 4'hB) begin
        if (op == 4'h4 || op == 4'h5 || op == 4'h8) begin
          bit [7:0] code = (op == 4'h5) ? mPre[c] : arg;
          if (!mPlay[c]) begin
            mPlay[c] = 1; mCur[c] = code; mCurSil[c] = (op == 4'h8); mStart[c] = 1;
          end else if (!mQueued[c]) begin
            mQueued[c] = 1; mQ[c] = code; mQSil[c] = (op == 4'h8);
          end
        end
        if (op == 4'h7) begin mPlay[c] = 0; mQueued[c] = 0; mLoop[c] = 0; mStop[c] = 1; end
        if (op == 4'h9 && mPlay[c]) mLoop[c] = 1;
        if (op == 4'hA) mLoop[c] = 0;
        if (op == 4'hB) mVol[c] = arg;
        if (op == 4'h6) mPre[c] = arg;
      end else if (pe[c] && mPlay[c]) begin
        if (mLoop[c]) mStart[c] = 1;
        else if (mQueued[c]) begin
          mCur[c] = mQ[c]; mCurSil[c] = mQSil[c]; mQueued[c] = 0; mStart[c] = 1;
        end else mPlay[c] = 0;
      end
    end
  endtask

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(input string tag);
    logic [1:0] eBusy, eNcr, eStart, eStop, eSil, eLoop;
    logic [15:0] eCode, eVol;
    for (int c = 0; c < 2; c++) begin
      eBusy[c] = !(mCnt != 0 || mPlay[c]);
      eNcr[c]  = !(mCnt != 0 || mQueued[c]);
      eStart[c] = mStart[c]; eStop[c] = mStop[c];
      eSil[c] = mCurSil[c]; eLoop[c] = mLoop[c];
      eCode[c*8 +: 8] = mCur[c]; eVol[c*8 +: 8] = mVol[c];
    end
    check({busyN, ncrN} === {eBusy, eNcr}, tag, "status", {busyN, ncrN}, {eBusy, eNcr});
    check({chStart, chStop} === {eStart, eStop}, tag, "pulses", {chStart, chStop}, {eStart, eStop});
    check({chSilence, chCode} === {eSil, eCode}, tag, "item", {chSilence, chCode}, {eSil, eCode});
    check({chLoop, chVol, pwrOn} === {eLoop, eVol, mPwr}, tag, "loop/vol/pwr",
          {chLoop, chVol, pwrOn}, {eLoop, eVol, mPwr});
  endtask

  task automatic cyc(input bit bv, input bit [7:0] bd, input bit [1:0] pe, input string tag);
    byteValid = bv; byteData = bd; phraseEnd = pe;
    @(posedge clk);
    #1 modelStep(bv, bd, pe);
    @(negedge clk);
    compareAll(tag);
    byteValid = 0; phraseEnd = 0;
  endtask

  task automatic idle(input int n, input string tag);
    repeat (n) cyc(0, 8'h00, 2'b00, tag);
  endtask

  task automatic cmd1(input bit [7:0] b, input string tag);
    cyc(1, b, 2'b00, tag); idle(9, tag);
  endtask

  task automatic cmd2(input bit [7:0] b0, input bit [7:0] b1, input string tag);
    cyc(1, b0, 2'b00, tag); cyc(1, b1, 2'b00, tag); idle(9, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    @(negedge clk); @(negedge clk);
    compareAll("R1");                 // R1 during reset
    rstN = 1'b1;
    idle(2, "R1");                    // R1 after release

    cmd1(8'h10, "R12"); cmd1(8'h30, "R12"); cmd1(8'h00, "R12");
    cmd2(8'h41, 8'h05, "R4");         // R4 play ch1 from idle
    cyc(1, 8'h41, 2'b00, "R3");       // R3: second byte arrives inside window? no: first byte
    cyc(1, 8'h06, 2'b00, "R3");
    cyc(1, 8'h41, 2'b00, "R3");       // dropped inside window
    idle(9, "R3");
    cmd2(8'h41, 8'h07, "R5");         // queue full: dropped
    cyc(0, 0, 2'b01, "R6"); idle(2, "R6");   // queued item starts
    cyc(0, 0, 2'b01, "R6"); idle(2, "R6");   // channel goes idle
    cmd2(8'h63, 8'h21, "R7"); cmd1(8'h53, "R7");
    cmd2(8'h82, 8'h10, "R8");         // queued silence on ch2
    cyc(0, 0, 2'b10, "R8"); idle(2, "R8");
    cmd1(8'h91, "R9");
    cyc(0, 0, 2'b01, "R9"); idle(2, "R9");
    cmd1(8'hA1, "R9");
    cmd1(8'h73, "R10");
    cmd1(8'h92, "R9");                // ch2 idle: no effect
    cmd2(8'hB2, 8'h1F, "R11"); cmd2(8'hB3, 8'h08, "R11");
    cmd1(8'hE5, "R13"); cmd1(8'hF3, "R13"); cmd1(8'hC0, "R13");
    cmd2(8'h41, 8'h33, "R14");
    cyc(1, 8'h41, 2'b00, "R14"); cyc(1, 8'h44, 2'b01, "R14"); idle(9, "R14");
    cyc(1, 8'h71, 2'b01, "R14"); idle(9, "R14");

    for (int n = 0; n < 6000; n++) begin
      bit bv = ($urandom % 3) == 0;
      bit [7:0] bd = $urandom;
      bit [1:0] pe = {($urandom % 8) == 0, ($urandom % 8) == 0};
      if (bd[7:4] == 4'h7 && ($urandom % 2)) bd[7:4] = 4'h4;
      cyc(bv, bd, pe, "R2");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule